// File: doc/BRIEF.md
# Downstream Command Issue Engine

This block is the software-facing command launcher of a host-side serial bus controller. Firmware first fills three header words and one data word through a simple register write port. It then writes header word 0 with its busy bit set, and that write launches the command toward the attached peripheral. The busy bit reads back as 1 until hardware clears it. Hardware clears it when a response arrives or when a programmable cycle limit runs out.

Each outcome is recorded in a sticky status register whose bits are cleared by writing 1. One bit records completion, and separate bits record each error cause. The status register is combined with an interrupt-enable register to drive one interrupt line. When a configuration read completes without error, the 32-bit value the peripheral returns is placed in header word 1, where software reads it back. The peripheral side is a plain response interface carrying a valid strobe, six error flags and 32 bits of read data.

Top module: `ncmd_engine`

## Requirements
- R1: After reset, all four command words, the status register and the interrupt enable read 0. The busy bit is 0, `irq` is 0, and the timeout limit at offset 0x18 reads the parameter `TMO_INIT` (default 1000).
- R2: Header word 0 is at offset 0x00, header word 1 at 0x04, header word 2 at 0x08 and the data word at 0x0C, and each reads back what was written. Bit 3 of header word 0 always reads the busy state.
- R3: Header word 0 holds the command type in [2:0] (0 set-config, 1 get-config, 2 in-band reset, 4 peripheral, 5 virtual wire, 6 out-of-band, 7 flash), busy in [3], target select in [5:4], and header bytes in [15:8], [23:16] and [31:24]. A write to it with bit 3 = 1 while idle sets busy and pulses `cmd_launch` for exactly one cycle after the write edge. The `cmd_hdr0`..`cmd_data` outputs then present the four words, with bit 3 of `cmd_hdr0` at 1. A write with bit 3 = 0 only stores the word.
- R4: While busy, writes to offsets 0x00, 0x04, 0x08 and 0x0C are ignored, and the stored command words are left unchanged.
- R5: A response (`rsp_valid`) while busy clears busy and sets status bit 28. It also sets error bits from `rsp_err`: [0]→bit 0 bus error, [1]→bit 1 wait timeout, [2]→bit 2 CRC, [3]→bit 4 no response, [4]→bit 5 fatal, [5]→bit 6 non-fatal.
- R6: When a get-configuration command (type 1) completes with `rsp_err` = 0, `rsp_data` is loaded into header word 1. For any other outcome, header word 1 keeps its value.
- R7: If no response arrives while the busy-cycle count stays below the limit at 0x18, hardware sets status bit 4 and clears busy, and leaves bit 28 clear.
- R8: The status register at 0x10 is write-one-to-clear. A hardware set wins over a clear in the same cycle. Only bits 28, 6, 5, 4, 2, 1 and 0 exist, and this also applies to the enable register at 0x14.
- R9: `irq` is 1 exactly when the bitwise AND of the status and enable registers is nonzero.
- R10: A response that arrives while idle changes neither the status register nor the command words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 5 | Register read byte offset |
| rd_data | output | 32 | Register read data (combinational) |
| cmd_launch | output | 1 | One-cycle pulse when a command starts |
| cmd_hdr0 | output | 32 | Launched header word 0 |
| cmd_hdr1 | output | 32 | Launched header word 1 |
| cmd_hdr2 | output | 32 | Launched header word 2 |
| cmd_data | output | 32 | Launched data word |
| rsp_valid | input | 1 | Peripheral response strobe |
| rsp_err | input | 6 | Peripheral error flags |
| rsp_data | input | 32 | Configuration read data |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `rsp_valid` lasts one cycle. They also assume that software leaves the timeout limit unchanged while a command is in flight, because the busy-length window check reads the limit live. The stimulus drives every response as a one-cycle pulse and only writes the limit while idle. Random response delays stay well under the programmed limit, so the random loop never hits a timeout, and timeouts are produced only by the directed case.

// File: rtl/ncmd_pkg.sv
package ncmd_pkg;
  localparam int DW     = 32;
  localparam int AW     = 5;
  localparam int NWORDS = 4;
  localparam int ERR_W  = 6;

  localparam logic [AW-1:0] OFS_HDR0 = 5'h00;
  localparam logic [AW-1:0] OFS_STS  = 5'h10;
  localparam logic [AW-1:0] OFS_IEN  = 5'h14;
  localparam logic [AW-1:0] OFS_TMO  = 5'h18;

  localparam int BUSY_BIT = 3;
  localparam int DONE_BIT = 28;
  localparam int NORSP_BIT = 4;
  localparam logic [DW-1:0] STS_MASK = 32'h1000_0077;

  typedef enum logic [2:0] {
    CT_SETCFG = 3'd0, CT_GETCFG = 3'd1, CT_INBRST = 3'd2, CT_RSVD3 = 3'd3,
    CT_PERIPH = 3'd4, CT_VWIRE  = 3'd5, CT_OOBAND = 3'd6, CT_FLASH = 3'd7
  } cmd_kind_e;

  // Maps peripheral error flags onto their status bit positions.
  function automatic logic [DW-1:0] err_to_sts(input logic [ERR_W-1:0] e);
    logic [DW-1:0] r;
    r = '0;
    r[0] = e[0];
    r[1] = e[1];
    r[2] = e[2];
    r[4] = e[3];
    r[5] = e[4];
    r[6] = e[5];
    return r;
  endfunction

  function automatic logic is_cfg_read(input logic [DW-1:0] h0);
    return cmd_kind_e'(h0[2:0]) == CT_GETCFG;
  endfunction
endpackage

// File: rtl/ncmd_words.sv
module ncmd_words
  import ncmd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic                 busy,
  input  logic                 cfg_load,
  input  logic [DW-1:0]        cfg_data,
  output logic [NWORDS-1:0][DW-1:0] words
);
  logic word_space;
  assign word_space = (wr_addr[AW-1:4] == '0) && (wr_addr[1:0] == 2'b00);

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    logic sel;
    assign sel = wr_en && !busy && word_space && (wr_addr[3:2] == i[1:0]);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        words[i] <= '0;
      end else if (sel) begin
        words[i] <= (i == 0) ? (wr_data & ~(DW'(1) << BUSY_BIT)) : wr_data;
      end else if (i == 1 && cfg_load) begin
        words[i] <= cfg_data;
      end
    end
  end
endmodule

// File: rtl/ncmd_seq.sv
module ncmd_seq #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_req,
  input  logic             rsp_valid,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             busy,
  output logic             launch_evt,
  output logic             rsp_evt,
  output logic             tmo_evt,
  output logic             launch_pulse
);
  logic [TMO_W-1:0] wait_cnt;

  assign launch_evt = go_req && !busy;
  assign rsp_evt    = busy && rsp_valid;
  assign tmo_evt    = busy && !rsp_valid && (wait_cnt >= tmo_limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      wait_cnt     <= '0;
      launch_pulse <= 1'b0;
    end else begin
      launch_pulse <= launch_evt;
      if (launch_evt) begin
        busy     <= 1'b1;
        wait_cnt <= '0;
      end else if (rsp_evt || tmo_evt) begin
        busy <= 1'b0;
      end else if (busy) begin
        wait_cnt <= wait_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ncmd_status.sv
module ncmd_status
  import ncmd_pkg::*;
#(
  parameter int TMO_W = 16,
  parameter logic [TMO_W-1:0] TMO_INIT = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [DW-1:0]    set_bits,
  output logic [DW-1:0]    sts,
  output logic [DW-1:0]    ien,
  output logic [TMO_W-1:0] tmo_limit,
  output logic             irq
);
  logic [DW-1:0] clr_bits;
  assign clr_bits = (wr_en && wr_addr == OFS_STS) ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts       <= '0;
      ien       <= '0;
      tmo_limit <= TMO_INIT;
    end else begin
      sts <= ((sts & ~clr_bits) | set_bits) & STS_MASK;
      if (wr_en && wr_addr == OFS_IEN) ien <= wr_data & STS_MASK;
      if (wr_en && wr_addr == OFS_TMO) tmo_limit <= wr_data[TMO_W-1:0];
    end
  end

  assign irq = |(sts & ien);
endmodule

// File: rtl/ncmd_engine.sv
module ncmd_engine
  import ncmd_pkg::*;
#(
  parameter int TMO_W = 16,
  parameter logic [TMO_W-1:0] TMO_INIT = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  output logic             cmd_launch,
  output logic [DW-1:0]    cmd_hdr0,
  output logic [DW-1:0]    cmd_hdr1,
  output logic [DW-1:0]    cmd_hdr2,
  output logic [DW-1:0]    cmd_data,
  input  logic             rsp_valid,
  input  logic [ERR_W-1:0] rsp_err,
  input  logic [DW-1:0]    rsp_data,
  output logic             irq
);
  logic [NWORDS-1:0][DW-1:0] words;
  logic [DW-1:0]    sts, ien, set_bits;
  logic [TMO_W-1:0] tmo_limit;
  logic busy, go_req, launch_evt, rsp_evt, tmo_evt, cfg_load;

  assign go_req   = wr_en && wr_addr == OFS_HDR0 && wr_data[BUSY_BIT];
  assign cfg_load = rsp_evt && rsp_err == '0 && is_cfg_read(words[0]);
  assign set_bits = rsp_evt ? (err_to_sts(rsp_err) | (DW'(1) << DONE_BIT))
                  : tmo_evt ? (DW'(1) << NORSP_BIT) : '0;

  ncmd_words u_words (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .busy,
    .cfg_load, .cfg_data(rsp_data), .words
  );

  ncmd_seq #(.TMO_W(TMO_W)) u_seq (
    .clk, .rst_n, .go_req, .rsp_valid, .tmo_limit, .busy,
    .launch_evt, .rsp_evt, .tmo_evt, .launch_pulse(cmd_launch)
  );

  ncmd_status #(.TMO_W(TMO_W), .TMO_INIT(TMO_INIT)) u_sts (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .set_bits,
    .sts, .ien, .tmo_limit, .irq
  );

  assign cmd_hdr0 = words[0] | (DW'(busy) << BUSY_BIT);
  assign cmd_hdr1 = words[1];
  assign cmd_hdr2 = words[2];
  assign cmd_data = words[3];

  always_comb begin
    case (rd_addr)
      5'h00:   rd_data = cmd_hdr0;
      5'h04:   rd_data = words[1];
      5'h08:   rd_data = words[2];
      5'h0C:   rd_data = words[3];
      OFS_STS: rd_data = sts;
      OFS_IEN: rd_data = ien;
      OFS_TMO: rd_data = DW'(tmo_limit);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/ncmd_checker.sv
module ncmd_checker
  import ncmd_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic             rsp_valid,
  input logic             busy,
  input logic             launch_evt,
  input logic             tmo_evt,
  input logic             cmd_launch,
  input logic [DW-1:0]    cmd_hdr0,
  input logic [DW-1:0]    sts,
  input logic [DW-1:0]    ien,
  input logic [TMO_W-1:0] tmo_limit,
  input logic             irq
);
  logic [TMO_W+1:0] busy_run;
  always_ff @(posedge clk) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else           busy_run <= '0;
  end

  p_launch_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    launch_evt |=> busy && cmd_launch);
  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_launch |=> !cmd_launch);
  p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_en && wr_addr == 5'h00 |=> $stable(cmd_hdr0[31:4]) && $stable(cmd_hdr0[2:0]));
  p_done_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rsp_valid |=> !busy && sts[DONE_BIT]);
  p_tmo_norsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> !busy && sts[NORSP_BIT]);
  p_busy_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= {2'b00, tmo_limit} + 2);
  p_sts_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sts & ~STS_MASK) == '0);
  p_irq_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ien == '0 |-> !irq);
  p_idle_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && rsp_valid && !(wr_en && wr_addr == OFS_STS) |=> $stable(sts));
endmodule

bind ncmd_engine ncmd_checker #(.TMO_W(TMO_W)) u_chk (
  .clk, .rst_n, .wr_en, .wr_addr, .rsp_valid, .busy, .launch_evt, .tmo_evt,
  .cmd_launch, .cmd_hdr0, .sts, .ien, .tmo_limit, .irq
);

// File: tb/sim_ncmd_engine.sv
`timescale 1ns/1ps
module sim_ncmd_engine;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [4:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic cmd_launch, irq;
  logic [31:0] cmd_hdr0, cmd_hdr1, cmd_hdr2, cmd_data;
  logic rsp_valid = 0;
  logic [5:0] rsp_err = 0;
  logic [31:0] rsp_data = 0;
  int checks = 0, failures = 0, cycles = 0;

  always #2.5 clk = ~clk;

  ncmd_engine u0 (.*);

  function automatic logic [31:0] exp_sts(input logic [5:0] e);
    return {3'b0, 1'b1, 21'b0, e[5:3], 1'b0, e[2:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    rd_addr = a; #0.5; d = rd_data;
  endtask

  task automatic respond(input logic [5:0] e, input logic [31:0] d);
    @(negedge clk); rsp_valid = 1; rsp_err = e; rsp_data = d;
    @(negedge clk); rsp_valid = 0; rsp_err = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, h0, h1, h2, dw, rv;
    logic [5:0] e;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(5'h00, v); chk("R1 hdr0", v, 0);
    rd(5'h10, v); chk("R1 sts", v, 0);
    rd(5'h18, v); chk("R1 tmo", v, 1000);
    chk("R1 irq", {31'b0, irq}, 0);
    // R2 plain storage, R3 no launch when busy bit clear
    wr(5'h04, 32'hA5A5_0001); wr(5'h08, 32'h0000_00C3); wr(5'h0C, 32'hDEAD_BEEF);
    wr(5'h00, 32'h1234_5631);
    chk("R3 no launch", {31'b0, cmd_launch}, 0);
    rd(5'h00, v); chk("R2 hdr0", v, 32'h1234_5631);
    rd(5'h04, v); chk("R2 hdr1", v, 32'hA5A5_0001);
    rd(5'h0C, v); chk("R2 data", v, 32'hDEAD_BEEF);
    // R10 idle response ignored
    respond(6'h3F, 32'h1111_1111);
    rd(5'h10, v); chk("R10 sts", v, 0);
    rd(5'h04, v); chk("R10 hdr1", v, 32'hA5A5_0001);
    // R8 mask on enable register
    wr(5'h14, 32'hFFFF_FFFF);
    rd(5'h14, v); chk("R8 ien mask", v, 32'h1000_0077);
    wr(5'h14, 0);
    wr(5'h18, 60);
    // Random commands: R3 R4 R5 R6
    for (int i = 0; i < 40; i++) begin
      h0 = $urandom & 32'hFFFF_FFF7; h1 = $urandom; h2 = $urandom; dw = $urandom;
      if (i % 4 == 0) h0[2:0] = 3'd1;
      e = ($urandom % 3 == 0) ? 6'($urandom) : 6'd0;
      rv = $urandom;
      wr(5'h04, h1); wr(5'h08, h2); wr(5'h0C, dw);
      wr(5'h00, h0 | 32'h8);
      chk("R3 pulse", {31'b0, cmd_launch}, 1);
      chk("R3 hdr0 out", cmd_hdr0, h0 | 32'h8);
      chk("R3 data out", cmd_data, dw);
      wr(5'h00, ~h0);
      chk("R3 pulse once", {31'b0, cmd_launch}, 0);
      wr(5'h08, ~h2);
      chk("R4 hdr0 kept", cmd_hdr0, h0 | 32'h8);
      chk("R4 hdr2 kept", cmd_hdr2, h2);
      repeat ($urandom % 6) @(negedge clk);
      respond(e, rv);
      rd(5'h00, v); chk("R5 busy clear", {31'b0, v[3]}, 0);
      rd(5'h10, v); chk("R5 status", v, exp_sts(e));
      rd(5'h04, v);
      chk("R6 hdr1", v, (h0[2:0] == 3'd1 && e == 0) ? rv : h1);
      wr(5'h10, exp_sts(e));
      rd(5'h10, v); chk("R8 w1c", v, 0);
    end
    // R7 timeout
    wr(5'h18, 5);
    wr(5'h00, 32'h0000_0004 | 32'h8);
    repeat (3) @(negedge clk);
    rd(5'h00, v); chk("R7 still busy", {31'b0, v[3]}, 1);
    repeat (10) @(negedge clk);
    rd(5'h00, v); chk("R7 busy cleared", {31'b0, v[3]}, 0);
    rd(5'h10, v); chk("R7 norsp only", v, 32'h0000_0010);
    wr(5'h10, 32'hFFFF_FFFF);
    // R8 set beats clear, R9 irq
    wr(5'h18, 60);
    wr(5'h00, 32'h8);
    @(negedge clk);
    rsp_valid = 1; rsp_err = 0; wr_en = 1; wr_addr = 5'h10; wr_data = 32'hFFFF_FFFF;
    @(negedge clk);
    rsp_valid = 0; wr_en = 0;
    rd(5'h10, v); chk("R8 set wins", v, 32'h1000_0000);
    chk("R9 irq off", {31'b0, irq}, 0);
    wr(5'h14, 32'h1000_0000);
    chk("R9 irq on", {31'b0, irq}, 1);
    wr(5'h14, 32'h0000_0001);
    chk("R9 irq masked", {31'b0, irq}, 0);
    wr(5'h10, 32'h1000_0000);
    wr(5'h14, 32'h1000_0000);
    chk("R9 irq after clear", {31'b0, irq}, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule